// File: doc/BRIEF.md
# Factored Sync-Code Correlator

This block correlates a stream of complex samples against a fixed 256-chip code whose chips are all +1 or -1, and emits one correlation result for each accepted sample. It does not use a 256-tap multiplier-free FIR. The code has a nested structure, so the correlation splits into five small adder stages. Each stage is fed from a short history of the stage before it. Only a handful of complex additions and subtractions are needed per output. The real and imaginary parts run through identical lanes.

A per-sample mode input selects what the result holds. In the default mode it holds the complex correlation. In the other mode it holds a signed combination of the squared magnitudes of the four terms that build the final stage, which is used while estimating frequency offset at start-up. Samples arrive with a valid strobe. Results leave with their own valid strobe one clock after the sample that produced them.

Top module: `gcor_top`

## Requirements
- R1: In complex mode each result equals the chain s1(k)=x(k-6)+x(k-4)+x(k-2)-x(k); U2(k)=s1(k-1)+s1(k), L2(k)=s1(k-1)-s1(k); s3(k)=U2(k-8)+L2(k); U4(k)=s3(k-48)+s3(k-16)+s3(k-32)-s3(k), L4(k)=s3(k-48)+s3(k-16)-s3(k-32)+s3(k); y(k)=U4(k-192)-L4(k-128)+U4(k-64)+L4(k). Here k counts accepted samples.
- R2: The chain is a direct correlation of 256 taps, x(k-n) for n=0..255, and every tap weight is exactly +1 or -1.
- R3: No valid result appears for the first 255 accepted samples after reset. Every accepted sample from the 256th onward produces exactly one valid result.
- R4: The result for a sample is registered on the clock edge that accepts it and is visible with out_valid_o high in the next cycle. out_valid_o is low in every other cycle.
- R5: When mode_pwr_i is 0 with a sample, its result carries y in out_re_o/out_im_o, and out_pwr_o is 0.
- R6: When mode_pwr_i is 1 with a sample, out_pwr_o carries |U4(k-192)|^2-|L4(k-128)|^2+|U4(k-64)|^2+|L4(k)|^2, and out_re_o and out_im_o are 0.
- R7: The mode may change on any sample without disturbing the histories. Results in both modes stay correct when the mode alternates every sample.
- R8: A cycle with in_valid_i low advances no history and leaves all result ports unchanged.
- R9: Full-scale inputs (-128 and +127, arranged to match or oppose the code) give exact results without wrap in either mode.
- R10: Reset clears every history and all result ports. After reset the fill count of R3 starts again, and no sample from before the reset contributes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_re_i | input | 8 | Sample real part, two's complement |
| in_im_i | input | 8 | Sample imaginary part, two's complement |
| mode_pwr_i | input | 1 | 0: complex result, 1: power result for this sample |
| out_valid_o | output | 1 | Result strobe |
| out_re_o | output | 17 | Correlation real part |
| out_im_o | output | 17 | Correlation imaginary part |
| out_pwr_o | output | 33 | Signed power combination |

## Verification
A pseudo-random stream checks the complex and power results against direct 256-term sums. A single impulse walks through the window so that each tap weight appears at the output on its own, which exposes any wrong sign or delay in one stage. Streams built from the code's own sign pattern at full scale, and from its opposite, reach the largest positive and negative peaks and would show any width that is too narrow. Sparse valid strobes, per-sample mode alternation and a reset in mid-stream separate faults in history gating, mode steering and clearing from faults in the arithmetic.

// File: rtl/gcor_pkg.sv
package gcor_pkg;

    typedef enum logic {
        OUT_CPLX = 1'b0,
        OUT_PWR  = 1'b1
    } gcor_mode_e;

    // Width that holds a signed sum of n_terms values of in_w bits each,
    // each added or subtracted, with no wrap.
    function automatic int sum_w(input int in_w, input int n_terms);
        return in_w + $clog2(n_terms) + 1;
    endfunction

endpackage

// File: rtl/gcor_delay_line.sv
module gcor_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      shift_i,
    input  logic [W-1:0]              data_i,
    output logic [DEPTH-1:0][W-1:0]   hist_o
);
    // hist_o[d] holds the value accepted d+1 shifts ago.
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] tap;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_i) begin
            line_d.tap[0] = data_i;
            for (int i = 1; i < DEPTH; i++) begin
                line_d.tap[i] = line_q.tap[i-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end

    assign hist_o = line_q.tap;

endmodule

// File: rtl/gcor_lane.sv
module gcor_lane
    import gcor_pkg::*;
#(
    parameter int X_W = 8
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  shift_i,
    input  logic [X_W-1:0]                        x_i,
    output logic [sum_w(X_W, 256)-1:0]            y_o,
    output logic [3:0][sum_w(X_W, 64)-1:0]        term_o
);
    localparam int S1_W = sum_w(X_W, 4);
    localparam int S2_W = sum_w(X_W, 8);
    localparam int S3_W = sum_w(X_W, 16);
    localparam int S4_W = sum_w(X_W, 64);
    localparam int Y_W  = sum_w(X_W, 256);
    localparam int D_X  = 6;
    localparam int D_S1 = 1;
    localparam int D_U2 = 8;
    localparam int D_S3 = 48;
    localparam int D_U4 = 192;
    localparam int D_L4 = 128;

    logic [D_X-1:0][X_W-1:0]   x_h;
    logic [D_S1-1:0][S1_W-1:0] s1_h;
    logic [D_U2-1:0][S2_W-1:0] u2_h;
    logic [D_S3-1:0][S3_W-1:0] s3_h;
    logic [D_U4-1:0][S4_W-1:0] u4_h;
    logic [D_L4-1:0][S4_W-1:0] l4_h;

    logic signed [S1_W-1:0] s1;
    logic signed [S2_W-1:0] u2, l2;
    logic signed [S3_W-1:0] s3;
    logic signed [S4_W-1:0] pair_sum, pair_dif, u4, l4;

    always_comb begin
        s1 = S1_W'($signed(x_h[5])) + S1_W'($signed(x_h[3]))
           + S1_W'($signed(x_h[1])) - S1_W'($signed(x_i));
        u2 = S2_W'($signed(s1_h[0])) + S2_W'(s1);
        l2 = S2_W'($signed(s1_h[0])) - S2_W'(s1);
        s3 = S3_W'($signed(u2_h[D_U2-1])) + S3_W'(l2);
        // Shared partial terms: the two branches differ only in one pair.
        pair_sum = S4_W'($signed(s3_h[47])) + S4_W'($signed(s3_h[15]));
        pair_dif = S4_W'($signed(s3_h[31])) - S4_W'(s3);
        u4 = pair_sum + pair_dif;
        l4 = pair_sum - pair_dif;
        y_o = Y_W'($signed(u4_h[191])) - Y_W'($signed(l4_h[127]))
            + Y_W'($signed(u4_h[63]))  + Y_W'(l4);
        term_o[0] = u4_h[191];
        term_o[1] = l4_h[127];
        term_o[2] = u4_h[63];
        term_o[3] = l4;
    end

    gcor_delay_line #(.W(X_W),  .DEPTH(D_X))  i_x_line  (.clk_i, .rst_ni, .shift_i, .data_i(x_i), .hist_o(x_h));
    gcor_delay_line #(.W(S1_W), .DEPTH(D_S1)) i_s1_line (.clk_i, .rst_ni, .shift_i, .data_i(s1),  .hist_o(s1_h));
    gcor_delay_line #(.W(S2_W), .DEPTH(D_U2)) i_u2_line (.clk_i, .rst_ni, .shift_i, .data_i(u2),  .hist_o(u2_h));
    gcor_delay_line #(.W(S3_W), .DEPTH(D_S3)) i_s3_line (.clk_i, .rst_ni, .shift_i, .data_i(s3),  .hist_o(s3_h));
    gcor_delay_line #(.W(S4_W), .DEPTH(D_U4)) i_u4_line (.clk_i, .rst_ni, .shift_i, .data_i(u4),  .hist_o(u4_h));
    gcor_delay_line #(.W(S4_W), .DEPTH(D_L4)) i_l4_line (.clk_i, .rst_ni, .shift_i, .data_i(l4),  .hist_o(l4_h));

endmodule

// File: rtl/gcor_mag2.sv
module gcor_mag2 #(
    parameter int IN_W  = 15,
    parameter int OUT_W = 31
) (
    input  logic [IN_W-1:0]  re_i,
    input  logic [IN_W-1:0]  im_i,
    output logic [OUT_W-1:0] mag_o
);
    logic signed [OUT_W-1:0] re_x, im_x;

    always_comb begin
        re_x  = OUT_W'($signed(re_i));
        im_x  = OUT_W'($signed(im_i));
        mag_o = re_x * re_x + im_x * im_x;
    end

endmodule

// File: rtl/gcor_top.sv
module gcor_top
    import gcor_pkg::*;
#(
    parameter int X_W  = 8,
    parameter int SPAN = 256
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          in_valid_i,
    input  logic [X_W-1:0]                in_re_i,
    input  logic [X_W-1:0]                in_im_i,
    input  logic                          mode_pwr_i,
    output logic                          out_valid_o,
    output logic [sum_w(X_W, 256)-1:0]    out_re_o,
    output logic [sum_w(X_W, 256)-1:0]    out_im_o,
    output logic [2*sum_w(X_W, 64)+2:0]   out_pwr_o
);
    localparam int S4_W  = sum_w(X_W, 64);
    localparam int Y_W   = sum_w(X_W, 256);
    localparam int M_W   = 2 * S4_W + 1;
    localparam int P_W   = M_W + 2;
    localparam int CNT_W = $clog2(SPAN);
    localparam int FILL  = SPAN - 1;

    typedef struct packed {
        logic [CNT_W-1:0]     fill;
        logic                 vld;
        logic signed [Y_W-1:0] re;
        logic signed [Y_W-1:0] im;
        logic signed [P_W-1:0] pwr;
    } state_t;

    state_t st_d, st_q;
    gcor_mode_e mode;

    logic [1:0][X_W-1:0]            lane_x;
    logic [1:0][Y_W-1:0]            lane_y;
    logic [1:0][3:0][S4_W-1:0]      lane_term;
    logic [3:0][M_W-1:0]            term_mag;
    logic signed [P_W-1:0]          pwr_sum;

    assign mode      = gcor_mode_e'(mode_pwr_i);
    assign lane_x[0] = in_re_i;
    assign lane_x[1] = in_im_i;

    // One identical lane per component (0: real, 1: imaginary).
    for (genvar c = 0; c < 2; c++) begin : g_lane
        gcor_lane #(.X_W(X_W)) i_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .shift_i (in_valid_i),
            .x_i     (lane_x[c]),
            .y_o     (lane_y[c]),
            .term_o  (lane_term[c])
        );
    end

    for (genvar t = 0; t < 4; t++) begin : g_mag
        gcor_mag2 #(.IN_W(S4_W), .OUT_W(M_W)) i_mag (
            .re_i  (lane_term[0][t]),
            .im_i  (lane_term[1][t]),
            .mag_o (term_mag[t])
        );
    end

    always_comb begin
        pwr_sum = P_W'($signed(term_mag[0])) - P_W'($signed(term_mag[1]))
                + P_W'($signed(term_mag[2])) + P_W'($signed(term_mag[3]));
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid_i) begin
            if (st_q.fill != CNT_W'(FILL)) begin
                st_d.fill = st_q.fill + 1'b1;
            end else begin
                st_d.vld = 1'b1;
                if (mode == OUT_PWR) begin
                    st_d.re  = '0;
                    st_d.im  = '0;
                    st_d.pwr = pwr_sum;
                end else begin
                    st_d.re  = $signed(lane_y[0]);
                    st_d.im  = $signed(lane_y[1]);
                    st_d.pwr = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign out_re_o    = st_q.re;
    assign out_im_o    = st_q.im;
    assign out_pwr_o   = st_q.pwr;

endmodule

// File: rtl/gcor_props.sv
module gcor_props #(
    parameter int SPAN = 256,
    parameter int Y_W  = 17,
    parameter int P_W  = 33
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           in_valid_i,
    input logic           mode_pwr_i,
    input logic           out_valid_o,
    input logic [Y_W-1:0] out_re_o,
    input logic [Y_W-1:0] out_im_o,
    input logic [P_W-1:0] out_pwr_o
);
    localparam int SEEN_W = $clog2(SPAN) + 1;

    logic [SEEN_W-1:0] seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  seen_q <= '0;
        else if (in_valid_i && seen_q < SEEN_W'(SPAN)) seen_q <= seen_q + 1'b1;
    end

    AST_NO_EARLY_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> seen_q >= SEEN_W'(SPAN)); // R3
    AST_OUTPUT_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && seen_q >= SEEN_W'(SPAN - 1)) |=> out_valid_o); // R3
    AST_VALID_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $past(in_valid_i)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> (!out_valid_o && $stable(out_re_o) && $stable(out_im_o)
                         && $stable(out_pwr_o))); // R8
    AST_CPLX_PWR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !$past(mode_pwr_i)) |-> out_pwr_o == '0); // R5
    AST_PWR_CPLX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && $past(mode_pwr_i)) |-> (out_re_o == '0 && out_im_o == '0)); // R6

endmodule

bind gcor_top gcor_props #(.SPAN(SPAN), .Y_W(Y_W), .P_W(P_W)) i_gcor_props (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .mode_pwr_i  (mode_pwr_i),
    .out_valid_o (out_valid_o),
    .out_re_o    (out_re_o),
    .out_im_o    (out_im_o),
    .out_pwr_o   (out_pwr_o)
);

// File: tb/test_gcor_top.sv
`timescale 1ns/100ps
module test_gcor_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_re = '0;
    logic [7:0]        in_im = '0;
    logic              mode_pwr = 1'b0;
    logic              out_valid;
    logic [16:0]       out_re, out_im;
    logic [32:0]       out_pwr;

    always #2.5 clk = ~clk;

    gcor_top i_gcor_top (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
        .in_re_i(in_re), .in_im_i(in_im), .mode_pwr_i(mode_pwr),
        .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im),
        .out_pwr_o(out_pwr)
    );

    int checks = 0;
    int fails  = 0;
    int cy[256];
    int cu[64];
    int cl[64];
    int hre[$];
    int him[$];
    int nacc = 0;
    logic   e_vld = 1'b0;
    longint e_re = 0, e_im = 0, e_pwr = 0;
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[23:16]));
    endfunction

    // Tap weights from multiplying out each stage as a polynomial in the delay.
    task automatic build_code();
        int p1[7]  = '{-1, 0, 1, 0, 1, 0, 1};
        int p23[10] = '{-1, 1, 0, 0, 0, 0, 0, 0, 1, 1};
        int p3[16];
        int pu[49];
        int pl[49];
        foreach (p3[i]) p3[i] = 0;
        foreach (pu[i]) begin pu[i] = 0; pl[i] = 0; end
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 10; j++) p3[i+j] += p1[i] * p23[j];
        pu[0] = -1; pu[16] = 1; pu[32] = 1;  pu[48] = 1;
        pl[0] = 1;  pl[16] = 1; pl[32] = -1; pl[48] = 1;
        foreach (cu[i]) begin cu[i] = 0; cl[i] = 0; end
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 49; j++) begin
                cu[i+j] += p3[i] * pu[j];
                cl[i+j] += p3[i] * pl[j];
            end
        foreach (cy[i]) cy[i] = 0;
        for (int n = 0; n < 64; n++) begin
            cy[n]     += cl[n];
            cy[n+64]  += cu[n];
            cy[n+128] -= cl[n];
            cy[n+192] += cu[n];
        end
    endtask

    function automatic longint xs(input bit im, input int n);
        if (n >= hre.size()) return 0;
        return im ? him[n] : hre[n];
    endfunction

    function automatic longint branch(input bit upper, input bit im, input int d);
        longint s = 0;
        for (int n = 0; n < 64; n++) s += (upper ? cu[n] : cl[n]) * xs(im, d + n);
        return s;
    endfunction

    function automatic longint mag2(input bit upper, input int d);
        longint r = branch(upper, 1'b0, d);
        longint q = branch(upper, 1'b1, d);
        return r * r + q * q;
    endfunction

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic compare(input string req);
        chk("R3/R4", "out_valid", longint'(out_valid), longint'(e_vld));
        chk(req, "out_re", longint'($signed(out_re)), e_re);
        chk(req, "out_im", longint'($signed(out_im)), e_im);
        chk(req, "out_pwr", longint'($signed(out_pwr)), e_pwr);
    endtask

    // Drive one cycle (called at a falling edge), update the model, check next falling edge.
    task automatic step(input bit v, input int re, input int im, input bit md, input string req);
        in_valid = v; in_re = 8'(re); in_im = 8'(im); mode_pwr = md;
        e_vld = 1'b0;
        if (v) begin
            hre.push_front(re); him.push_front(im);
            if (hre.size() > 256) begin void'(hre.pop_back()); void'(him.pop_back()); end
            nacc++;
            if (nacc >= 256) begin
                e_vld = 1'b1;
                if (md) begin
                    e_re = 0; e_im = 0;
                    e_pwr = mag2(1, 192) - mag2(0, 128) + mag2(1, 64) + mag2(0, 0);
                end else begin
                    e_re = 0; e_im = 0; e_pwr = 0;
                    for (int n = 0; n < 256; n++) begin
                        e_re += cy[n] * xs(0, n);
                        e_im += cy[n] * xs(1, n);
                    end
                end
            end
        end
        @(negedge clk);
        compare(req);
        if (e_vld && !md) chk("R5", "pwr zero", longint'($signed(out_pwr)), 0);
        if (e_vld && md)  chk("R6", "re zero", longint'($signed(out_re)), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        hre.delete(); him.delete(); nacc = 0;
        e_vld = 1'b0; e_re = 0; e_im = 0; e_pwr = 0;
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin : main
        bit ok;
        build_code();
        // R2: every tap weight is +1 or -1
        ok = 1'b1;
        foreach (cy[i]) if (cy[i] != 1 && cy[i] != -1) ok = 1'b0;
        chk("R2", "tap weights", longint'(ok), 1);

        @(negedge clk);
        do_reset();  // R10 reset state

        // R1 R3: random stream, complex mode, through fill and beyond
        for (int i = 0; i < 420; i++) step(1, rnd8(), rnd8(), 0, "R1");

        // R8: sparse strobes freeze histories and hold outputs
        for (int i = 0; i < 240; i++) begin
            bit v = (rnd8() > 40);
            step(v, rnd8(), rnd8(), 0, "R8");
        end

        // R6: power mode
        for (int i = 0; i < 200; i++) step(1, rnd8(), rnd8(), 1, "R6");

        // R7: mode alternates every sample
        for (int i = 0; i < 200; i++) step(1, rnd8(), rnd8(), i[0], "R7");

        // R10: reset mid-stream, then impulse walking through the window (R2)
        do_reset();
        for (int i = 0; i < 560; i++) step(1, (i == 260) ? 1 : 0, (i == 260) ? -1 : 0, 0, "R2");

        // R9: full-scale code-matched and opposed patterns in both modes
        do_reset();
        for (int j = 0; j < 256; j++)
            step(1, cy[255-j] > 0 ? 127 : -128, cy[255-j] > 0 ? -128 : 127, 0, "R9");
        for (int j = 0; j < 256; j++)
            step(1, cy[255-j] > 0 ? 127 : -128, cy[255-j] > 0 ? -128 : 127, j[0], "R9");
        for (int j = 0; j < 300; j++) step(1, -128, -128, j[1], "R9");
        for (int j = 0; j < 300; j++) step(1, (j % 3 == 0) ? 127 : -128, -128, 1, "R9");

        step(0, 0, 0, 0, "R8");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule